// File: doc/BRIEF.md
# Command/Response FIFO Status Engine

This block is the byte-wide host side of a command/response exchange. The host first arms the engine by writing the ready bit of the status register. It then pushes a command one byte at a time through a single data port and writes the go bit. A stub executor stands in for the real command processor: it waits a programmable number of cycles, and the response it makes available is the host then pops through the same data port. The length of the command is decoded on the fly from a length field carried in the command header.

The status register reports five flags: valid, ready, go, data-available and data-expected. Two further byte addresses above it carry a 16-bit burst count, which tells the host how many bytes it can move now without stalling. Writing the ready bit at any point abandons the exchange in progress and re-arms the engine. The stub echoes the command back as the response. In that echo it rewrites the length field to the number of bytes actually supplied and zeroes the four result-code bytes.

Top module: `cmd_fifo_engine`

## Requirements
- R1: After reset, status (address 0x018) reads 0x80 (only bit 7 valid set), and both burst bytes (0x019 low, 0x01A high) read 0x00.
- R2: A write to 0x018 with bit 6 set moves the engine to the armed state from any state. On the next cycle status reads 0xC8 (valid, ready bit 6, expect bit 3) and burst reads MAX_LEN.
- R3: Writes to the data port (0x024) are dropped while data-expected is clear, and the status and burst are unchanged afterwards. Reads of the data port while data-available (bit 4) is clear return 0xFF.
- R4: Bytes 2 to 5 of the command hold a big-endian 32-bit total length. That length is clamped to no less than 10 and no more than MAX_LEN. Data-expected stays 1 until that many bytes have been accepted and reads 0 after the last one. The ready bit clears on the first accepted byte.
- R5: The burst count is little-endian across 0x019 and 0x01A. While the command is being received it equals MAX_LEN minus the bytes accepted. While the response is pending it equals the response bytes not yet read. In every other state it is 0.
- R6: A write with bit 5 set and bit 6 clear starts execution only when the command is complete. Data-available then reads 1 on the status read issued in the cycle exec_lat_i+2 after the go write. A go in any other state is ignored, and when bits 5 and 6 are written together the ready bit wins.
- R7: The response is the command with bytes 2 to 5 replaced by the clamped length (big-endian) and bytes 6 to 9 set to 0. Reading its last byte clears data-available, and status then reads 0x80.
- R8: In the cycle right after an accepted data-port write, status bit 7 reads 0. At all other times it reads 1.
- R9: An abort during reception, execution or response draining discards all held bytes. The engine stays armed with burst MAX_LEN, and an execution that was pending never raises data-available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write data |
| exec_lat_i | input | LAT_W | Cycles the stub executor waits after go |
| rdata_o | output | 8 | Read data for the current access (combinational) |

## Verification
A wrong byte counter or a badly decoded length shows at the ports at once: data-expected drops early or late, and the burst count read right after any byte write is off. A stuck or misrouted state shows on the next status read, as a wrong ready/expect/available pattern or as a burst count that is non-zero while the engine waits. Errors in how the response is assembled appear only when the drained bytes are compared against an echo of the command, which is why every exchange is drained in full and checked byte by byte. A lost abort shows one cycle later as a status value other than 0xC8.

// File: rtl/cmd_fifo_pkg.sv
package cmd_fifo_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_READY, S_RECV, S_FULL, S_EXEC, S_COMPL
  } eng_state_e;

  localparam int HDR_LEN   = 10;
  localparam int LEN_FIRST = 2;
  localparam int LEN_LAST  = 5;
  localparam int RC_FIRST  = 6;
  localparam int RC_LAST   = 9;

  localparam int B_VALID  = 7;
  localparam int B_READY  = 6;
  localparam int B_GO     = 5;
  localparam int B_AVAIL  = 4;
  localparam int B_EXPECT = 3;
endpackage

// File: rtl/cmd_fifo_store.sv
module cmd_fifo_store #(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [7:0]       wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [7:0]       rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cmd_fifo_exec_stub.sv
module cmd_fifo_exec_stub #(
  parameter int LAT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             done_o
);
  logic             busy_q;
  logic [LAT_W-1:0] cnt_q;

  assign done_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= lat_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/cmd_fifo_ctrl.sv
module cmd_fifo_ctrl
  import cmd_fifo_pkg::*;
#(
  parameter int MAX_LEN = 32,
  localparam int CNT_W = $clog2(MAX_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             go_i,
  input  logic             fifo_wr_i,
  input  logic             fifo_rd_i,
  input  logic [7:0]       wdata_i,
  input  logic             exec_done_i,
  output eng_state_e       state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rd_ptr_o,
  output logic [CNT_W-1:0] eff_len_o,
  output logic             wr_ok_o,
  output logic             start_o
);
  eng_state_e       state_q;
  logic [CNT_W-1:0] cnt_q, rd_ptr_q, eff_q;
  logic [31:0]      len_raw_q, len_next;
  logic [CNT_W-1:0] eff_next, cnt_inc;
  logic             in_len, done;

  assign wr_ok_o = fifo_wr_i && (state_q == S_READY || state_q == S_RECV);
  assign start_o = go_i && (state_q == S_FULL);
  assign cnt_inc = cnt_q + 1'b1;
  assign in_len  = (cnt_q >= CNT_W'(LEN_FIRST)) && (cnt_q <= CNT_W'(LEN_LAST));
  assign len_next = in_len ? {len_raw_q[23:0], wdata_i} : len_raw_q;

  // clamp header length into [HDR_LEN, MAX_LEN]
  always_comb begin
    if (len_next > 32'(MAX_LEN))      eff_next = CNT_W'(MAX_LEN);
    else if (len_next < 32'(HDR_LEN)) eff_next = CNT_W'(HDR_LEN);
    else                              eff_next = len_next[CNT_W-1:0];
  end

  assign done = (cnt_inc == eff_next) || (cnt_inc == CNT_W'(MAX_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      cnt_q     <= '0;
      rd_ptr_q  <= '0;
      eff_q     <= CNT_W'(HDR_LEN);
      len_raw_q <= '0;
    end else if (abort_i) begin
      state_q   <= S_READY;
      cnt_q     <= '0;
      rd_ptr_q  <= '0;
      eff_q     <= CNT_W'(HDR_LEN);
      len_raw_q <= '0;
    end else begin
      unique case (state_q)
        S_READY, S_RECV: if (wr_ok_o) begin
          cnt_q     <= cnt_inc;
          len_raw_q <= len_next;
          eff_q     <= eff_next;
          state_q   <= done ? S_FULL : S_RECV;
        end
        S_FULL:  if (start_o) state_q <= S_EXEC;
        S_EXEC:  if (exec_done_i) begin
          state_q  <= S_COMPL;
          rd_ptr_q <= '0;
        end
        S_COMPL: if (fifo_rd_i) begin
          rd_ptr_q <= rd_ptr_q + 1'b1;
          if (rd_ptr_q + 1'b1 == eff_q) state_q <= S_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign state_o   = state_q;
  assign cnt_o     = cnt_q;
  assign rd_ptr_o  = rd_ptr_q;
  assign eff_len_o = eff_q;
endmodule

// File: rtl/cmd_fifo_rdmux.sv
module cmd_fifo_rdmux
  import cmd_fifo_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int ADDR_W  = 12,
  parameter int BURST_W = 16,
  parameter logic [ADDR_W-1:0] STS_ADDR  = 'h018,
  parameter logic [ADDR_W-1:0] FIFO_ADDR = 'h024,
  localparam int CNT_W = $clog2(MAX_LEN + 1)
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  eng_state_e         state_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [CNT_W-1:0]   rd_ptr_i,
  input  logic [CNT_W-1:0]   eff_len_i,
  input  logic [7:0]         buf_byte_i,
  input  logic               settle_i,
  output logic [BURST_W-1:0] burst_o,
  output logic [7:0]         rdata_o
);
  logic [7:0]  sts, resp_byte;
  logic [31:0] eff32;
  logic        avail;

  assign avail = (state_i == S_COMPL);
  assign eff32 = 32'(eff_len_i);

  always_comb begin
    sts           = '0;
    sts[B_VALID]  = !settle_i;
    sts[B_READY]  = (state_i == S_READY);
    sts[B_AVAIL]  = avail;
    sts[B_EXPECT] = (state_i == S_READY) || (state_i == S_RECV);
  end

  always_comb begin
    unique case (state_i)
      S_READY, S_RECV: burst_o = BURST_W'(MAX_LEN) - BURST_W'(cnt_i);
      S_COMPL:         burst_o = BURST_W'(eff_len_i) - BURST_W'(rd_ptr_i);
      default:         burst_o = '0;
    endcase
  end

  // echo with length rewritten and result code cleared
  always_comb begin
    if (rd_ptr_i >= CNT_W'(LEN_FIRST) && rd_ptr_i <= CNT_W'(LEN_LAST))
      resp_byte = 8'(eff32 >> (8 * (LEN_LAST - int'(rd_ptr_i))));
    else if (rd_ptr_i >= CNT_W'(RC_FIRST) && rd_ptr_i <= CNT_W'(RC_LAST))
      resp_byte = 8'h00;
    else
      resp_byte = buf_byte_i;
  end

  always_comb begin
    if (addr_i == STS_ADDR)                rdata_o = sts;
    else if (addr_i == STS_ADDR + 1'b1)    rdata_o = burst_o[7:0];
    else if (addr_i == STS_ADDR + 2'd2)    rdata_o = burst_o[15:8];
    else if (addr_i == FIFO_ADDR && avail) rdata_o = resp_byte;
    else                                   rdata_o = 8'hFF;
  end
endmodule

// File: rtl/cmd_fifo_engine.sv
module cmd_fifo_engine
  import cmd_fifo_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int ADDR_W  = 12,
  parameter int LAT_W   = 16,
  parameter logic [ADDR_W-1:0] STS_ADDR  = 'h018,
  parameter logic [ADDR_W-1:0] FIFO_ADDR = 'h024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [LAT_W-1:0]  exec_lat_i,
  output logic [7:0]        rdata_o
);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam int IDX_W   = $clog2(MAX_LEN);
  localparam int BURST_W = 16;

  eng_state_e         state;
  logic [CNT_W-1:0]   cnt, rd_ptr, eff_len;
  logic [BURST_W-1:0] burst;
  logic [7:0]         buf_byte;
  logic               sts_wr, abort, go, fifo_wr, fifo_rd, wr_ok, start, exec_done;
  logic               settle_q;

  assign sts_wr  = req_i && we_i && (addr_i == STS_ADDR);
  assign abort   = sts_wr && wdata_i[B_READY];
  assign go      = sts_wr && wdata_i[B_GO] && !wdata_i[B_READY];
  assign fifo_wr = req_i && we_i && (addr_i == FIFO_ADDR);
  assign fifo_rd = req_i && !we_i && (addr_i == FIFO_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) settle_q <= 1'b0;
    else         settle_q <= wr_ok;
  end

  cmd_fifo_ctrl #(.MAX_LEN(MAX_LEN)) u_ctrl (
    .clk_i, .rst_ni,
    .abort_i(abort), .go_i(go), .fifo_wr_i(fifo_wr), .fifo_rd_i(fifo_rd),
    .wdata_i, .exec_done_i(exec_done),
    .state_o(state), .cnt_o(cnt), .rd_ptr_o(rd_ptr), .eff_len_o(eff_len),
    .wr_ok_o(wr_ok), .start_o(start)
  );

  cmd_fifo_store #(.DEPTH(MAX_LEN)) u_store (
    .clk_i,
    .we_i(wr_ok), .waddr_i(cnt[IDX_W-1:0]), .wdata_i,
    .raddr_i(rd_ptr[IDX_W-1:0]), .rdata_o(buf_byte)
  );

  cmd_fifo_exec_stub #(.LAT_W(LAT_W)) u_exec (
    .clk_i, .rst_ni,
    .start_i(start), .abort_i(abort), .lat_i(exec_lat_i), .done_o(exec_done)
  );

  cmd_fifo_rdmux #(
    .MAX_LEN(MAX_LEN), .ADDR_W(ADDR_W), .BURST_W(BURST_W),
    .STS_ADDR(STS_ADDR), .FIFO_ADDR(FIFO_ADDR)
  ) u_rdmux (
    .addr_i, .state_i(state), .cnt_i(cnt), .rd_ptr_i(rd_ptr),
    .eff_len_i(eff_len), .buf_byte_i(buf_byte), .settle_i(settle_q),
    .burst_o(burst), .rdata_o
  );
endmodule

// File: rtl/cmd_fifo_engine_chk.sv
module cmd_fifo_engine_chk
  import cmd_fifo_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] STS_ADDR  = 'h018,
  parameter logic [ADDR_W-1:0] FIFO_ADDR = 'h024
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input eng_state_e        state_i,
  input logic [15:0]       burst_i
);
  logic sts_w, fifo_w, fifo_r;
  assign sts_w  = req_i && we_i && (addr_i == STS_ADDR);
  assign fifo_w = req_i && we_i && (addr_i == FIFO_ADDR);
  assign fifo_r = req_i && !we_i && (addr_i == FIFO_ADDR);

  assert_abort_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_w && wdata_i[B_READY] |=> state_i == S_READY);

  assert_idle_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_IDLE && fifo_w |=> state_i == S_IDLE);

  assert_full_after_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_i == S_FULL) |-> $past(fifo_w));

  assert_burst_zero_wait_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_EXEC || state_i == S_FULL || state_i == S_IDLE) |-> burst_i == 16'd0);

  assert_go_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_IDLE && sts_w && !wdata_i[B_READY] |=> state_i == S_IDLE);

  assert_avail_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(state_i == S_COMPL) |-> $past(fifo_r || (sts_w && wdata_i[B_READY])));
endmodule

bind cmd_fifo_engine cmd_fifo_engine_chk #(
  .ADDR_W(ADDR_W), .STS_ADDR(STS_ADDR), .FIFO_ADDR(FIFO_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .state_i(state), .burst_i(burst)
);

// File: tb/cmd_fifo_engine_tb_top.sv
`timescale 1ns/1ps
module cmd_fifo_engine_tb_top;
  localparam int MAX_LEN = 32;
  localparam logic [11:0] STS = 12'h018, BLO = 12'h019, BHI = 12'h01A, FIFO = 12'h024;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0, rdata;
  logic [15:0] lat = '0;

  always #2 clk = ~clk;

  cmd_fifo_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .exec_lat_i(lat), .rdata_o(rdata)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] cmd [MAX_LEN];
  logic [7:0] exp_q [$];

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1 req = 0; we = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [7:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(posedge clk); #1 req = 0;
  endtask

  task automatic chk_rd(string tag, logic [11:0] a, int exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  function automatic int clamp(int f);
    if (f > MAX_LEN) return MAX_LEN;
    if (f < 10) return 10;
    return f;
  endfunction

  // fill command buffer; header length field = fld
  task automatic build(int fld, int seed);
    for (int i = 0; i < MAX_LEN; i++) cmd[i] = 8'((i * 7 + seed) & 255);
    cmd[0] = 8'h80; cmd[1] = 8'hC1;
    cmd[2] = 8'(fld >> 24); cmd[3] = 8'(fld >> 16);
    cmd[4] = 8'(fld >> 8);  cmd[5] = 8'(fld);
  endtask

  // driver: write n bytes, push expected response
  task automatic send(int n, int eff);
    for (int i = 0; i < n; i++) wr(FIFO, cmd[i]);
    for (int i = 0; i < eff; i++) begin
      if (i >= 2 && i <= 5)      exp_q.push_back(8'(eff >> (8 * (5 - i))));
      else if (i >= 6 && i <= 9) exp_q.push_back(8'h00);
      else                       exp_q.push_back(cmd[i]);
    end
  endtask

  // monitor: pop expected bytes and compare against the data port
  task automatic drain(int n);
    logic [7:0] v;
    for (int i = 0; i < n; i++) begin
      rd(FIFO, v);
      chk($sformatf("R7 resp byte %0d", i), v, exp_q.pop_front());
    end
  endtask

  task automatic poll_avail(output int n);
    logic [7:0] v;
    n = 0;
    do begin rd(STS, v); n++; end while (!v[4] && n < 2000);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    chk_rd("R1 status", STS, 8'h80);
    chk_rd("R1 burst lo", BLO, 0);
    chk_rd("R1 burst hi", BHI, 0);

    // R3 idle writes dropped, empty reads 0xFF
    wr(FIFO, 8'h5A);
    chk_rd("R3 status after dropped write", STS, 8'h80);
    chk_rd("R3 burst after dropped write", BLO, 0);
    chk_rd("R3 empty read", FIFO, 8'hFF);
    // R6 go ignored while idle
    wr(STS, 8'h20);
    chk_rd("R6 go in idle", STS, 8'h80);

    // R2 arm
    wr(STS, 8'h40);
    chk_rd("R2 armed status", STS, 8'hC8);
    chk_rd("R2 burst lo", BLO, MAX_LEN);
    chk_rd("R2 burst hi", BHI, 0);

    // command of 12 bytes
    build(12, 3);
    wr(FIFO, cmd[0]);
    chk_rd("R8 valid low after write", STS, 8'h08);
    chk_rd("R8 valid back", STS, 8'h88);
    chk_rd("R5 burst during recv", BLO, MAX_LEN - 1);
    for (int i = 1; i < 11; i++) wr(FIFO, cmd[i]);
    chk_rd("R8 settle", STS, 8'h08);
    chk_rd("R4 expect before last", STS, 8'h88);
    wr(FIFO, cmd[11]);
    chk_rd("R8 settle last", STS, 8'h00);
    chk_rd("R4 expect cleared", STS, 8'h80);
    chk_rd("R5 burst zero when full", BLO, 0);
    wr(FIFO, 8'hEE);
    chk_rd("R3 extra byte dropped", STS, 8'h80);
    for (int i = 0; i < 12; i++) begin
      if (i >= 2 && i <= 5)      exp_q.push_back(8'(12 >> (8 * (5 - i))));
      else if (i >= 6 && i <= 9) exp_q.push_back(8'h00);
      else                       exp_q.push_back(cmd[i]);
    end
    lat = 16'd5;
    wr(STS, 8'h20);
    poll_avail(n);
    chk("R6 latency 5", n, 7);
    chk_rd("R6 avail status", STS, 8'h90);
    chk_rd("R5 burst response", BLO, 12);
    drain(12);
    chk_rd("R7 status after drain", STS, 8'h80);
    chk_rd("R7 empty after drain", FIFO, 8'hFF);

    // clamp high: field 0x10000 -> MAX_LEN
    wr(STS, 8'h40);
    build(32'h0001_0000, 11);
    send(MAX_LEN - 1, MAX_LEN);
    chk_rd("R4 settle clamp", STS, 8'h08);
    chk_rd("R4 expect at MAX-1", STS, 8'h88);
    wr(FIFO, cmd[MAX_LEN-1]);
    chk_rd("R4 settle clamp full", STS, 8'h00);
    chk_rd("R4 clamp full", STS, 8'h80);
    lat = 16'd0;
    wr(STS, 8'h20);
    poll_avail(n);
    chk("R6 latency 0", n, 2);
    drain(5);
    chk_rd("R5 burst partial drain", BLO, MAX_LEN - 5);
    wr(STS, 8'h40);
    exp_q.delete();
    chk_rd("R9 abort in response", STS, 8'hC8);
    chk_rd("R9 burst after abort", BLO, MAX_LEN);
    chk_rd("R9 no data after abort", FIFO, 8'hFF);
    wr(STS, 8'h20);
    chk_rd("R6 go while armed", STS, 8'hC8);

    // clamp low with an abort mid-command first
    build(3, 20);
    for (int i = 0; i < 4; i++) wr(FIFO, cmd[i]);
    wr(STS, 8'h40);
    chk_rd("R9 abort in recv", STS, 8'hC8);
    chk_rd("R9 burst reset", BLO, MAX_LEN);
    send(10, 10);
    chk_rd("R8 settle low clamp", STS, 8'h00);
    chk_rd("R4 low clamp full", STS, 8'h80);
    lat = 16'd2;
    wr(STS, 8'h20);
    poll_avail(n);
    chk("R6 latency 2", n, 4);
    drain(10);
    chk_rd("R7 idle after low clamp", STS, 8'h80);

    // R6 go+ready together: ready wins
    wr(STS, 8'h40);
    build(10, 40);
    for (int i = 0; i < 10; i++) wr(FIFO, cmd[i]);
    wr(STS, 8'h60);
    chk_rd("R6 ready wins over go", STS, 8'hC8);

    // R9 abort during execution
    build(10, 50);
    for (int i = 0; i < 10; i++) wr(FIFO, cmd[i]);
    lat = 16'd50;
    wr(STS, 8'h20);
    repeat (3) @(posedge clk);
    wr(STS, 8'h40);
    chk_rd("R9 abort in exec", STS, 8'hC8);
    repeat (70) @(posedge clk);
    chk_rd("R9 no late avail", STS, 8'hC8);
    chk_rd("R9 burst after exec abort", BLO, MAX_LEN);

    finish_run();
  end
endmodule